// File: doc/BRIEF.md
# Packet Slot Restriction Checker

This block is a passive monitor for the command side of a packetized memory channel. In each packet cycle it samples up to one row packet and one column packet. Each packet carries a target device number, and a row packet also carries a broadcast flag and an operation field. The monitor follows two kinds of timing window. The first is the column placement window that opens after a row packet which sends a device back to standby. The second is the restricted and quiet windows that open after a row packet which puts a device into nap or powerdown.

When a packet falls in a slot the protocol forbids, the monitor raises a violation flag with an error code in the next cycle. A packet that reaches a device which has finished entering nap or powerdown is not a violation, because the device silently ignores it. The monitor reports such a packet on a separate drop flag. A wake input tells the monitor that a sleeping device has been brought back. The monitor assumes this input comes from the rest of the controller, which knows when a wake-up sequence has finished.

The frame length, the restricted interval length, the quiet interval length and the number of tracked devices are parameters. Offsets below are counted in packet cycles: offset 0 is the cycle of the row packet that opens the window.

Top module: `packet_slot_checker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset is released, `viol`, `viol_code` and `drop` are all zero.
- R2: Every result appears one clock after the packet that causes it. `viol` is high exactly when `viol_code` is non-zero. The code values are: 0 none, 1 column window, 2 restricted interval, 3 quiet interval. A cycle with no row packet and no column packet gives no flag.
- R3: A row packet with operation 1 (relax) opens a column window. A column packet to any device at offset FRAME-3, FRAME-2 or FRAME-1 gives code 1.
- R4: A column packet to the device named by the relax packet at offsets 1 to FRAME-4 gives code 1. A column packet to any other device at those offsets is legal. Column packets at offset 0 or at offset FRAME and later are legal. A later relax packet restarts the window.
- R5: A broadcast relax packet treats every device as the named device for the column window.
- R6: A non-broadcast row packet with operation 2 (nap) or 3 (powerdown) to an awake device opens a restricted interval for that device at offsets 1 to RESTR_LEN. Any non-broadcast row packet or column packet to that device in the interval gives code 2.
- R7: During a device's restricted interval, row and column packets to other devices are not flagged.
- R8: A nap or powerdown packet also opens a quiet interval at offsets 1 to QUIET_LEN. A broadcast row packet in a quiet interval gives code 3. Once the quiet interval has ended, a broadcast row packet is not flagged.
- R9: From offset RESTR_LEN+1 the device is asleep. A non-broadcast row packet or a column packet to it raises `drop` and not `viol`. A `wake_vld` pulse naming the device makes it awake from the next cycle.
- R10: When several faults fall in one cycle, code 2 is chosen over code 3, and code 3 over code 1.
- R11: A non-broadcast relax packet to a device that is in its restricted interval or asleep opens no column window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Packet-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_vld | input | 1 | A row packet is present this cycle |
| row_op | input | 2 | Row operation: 0 other, 1 relax, 2 nap, 3 powerdown |
| row_dev | input | DEV_W | Target device of the row packet |
| row_bcast | input | 1 | The row packet is broadcast to all devices |
| col_vld | input | 1 | A column packet is present this cycle |
| col_dev | input | DEV_W | Target device of the column packet |
| wake_vld | input | 1 | A sleeping device has been woken |
| wake_dev | input | DEV_W | Device that has been woken |
| viol | output | 1 | Placement violation seen in the previous cycle |
| viol_code | output | 3 | Code of that violation, 0 when none |
| drop | output | 1 | A packet in the previous cycle went to a sleeping device |

## Verification
The assertions assume that reset is held low for at least one clock edge, and that the inputs do not change near the rising edge. They also assume that `row_op` is meaningful only while `row_vld` is high, and that a wake pulse is sent only to a device the controller knows to be asleep. The bench drives every input on the falling half of the clock and holds all valid lines low when it is idle. It waits longer than FRAME and RESTR_LEN between scenarios, so no window left over from one scenario affects the next.

// File: rtl/slotchk_pkg.sv
// Shared encodings for the packet slot restriction checker.
// Assumes: row operation field is 2 bits, violation code is 3 bits.
package slotchk_pkg;

    typedef enum logic [1:0] {
        OP_OTHER = 2'd0,
        OP_RELAX = 2'd1,
        OP_NAP   = 2'd2,
        OP_PDN   = 2'd3
    } row_op_e;

    typedef enum logic [2:0] {
        VC_NONE   = 3'd0,
        VC_COLWIN = 3'd1,
        VC_RESTR  = 3'd2,
        VC_QUIET  = 3'd3
    } viol_code_e;

    typedef enum logic [1:0] {
        PS_AWAKE = 2'd0,
        PS_RESTR = 2'd1,
        PS_SLEEP = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/relax_window.sv
// Column placement window after a relax row packet.
// Keeps the offset since the last arming relax packet. It flags column
// packets that land in the window for the named device (or for every
// device when the relax packet was broadcast), and column packets to any
// device in the last three slots before the frame ends.
// Assumes: FRAME >= 5; arm is already qualified by the caller.
module relax_window #(
    parameter int FRAME = 8,
    parameter int DEV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [DEV_W-1:0] arm_dev,
    input  logic             arm_bcast,
    input  logic             col_vld,
    input  logic [DEV_W-1:0] col_dev,
    output logic             col_hit
);
    localparam int OFF_W = $clog2(FRAME + 1);
    localparam logic [OFF_W-1:0] LAST_OFF  = OFF_W'(FRAME - 1);
    localparam logic [OFF_W-1:0] GUARD_LO  = OFF_W'(FRAME - 3);

    logic [OFF_W-1:0] off_q;
    logic [DEV_W-1:0] dev_q;
    logic             bcast_q;
    logic             active;
    logic             same_dev;

    // Offset counter: restart on arm, count to FRAME-1, then go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q   <= '0;
            dev_q   <= '0;
            bcast_q <= 1'b0;
        end else if (arm) begin
            off_q   <= OFF_W'(1);
            dev_q   <= arm_dev;
            bcast_q <= arm_bcast;
        end else if (off_q == LAST_OFF) begin
            off_q   <= '0;
        end else if (off_q != '0) begin
            off_q   <= off_q + OFF_W'(1);
        end
    end

    // Window decode for the column packet of the current cycle.
    always_comb begin
        active   = (off_q != '0);
        same_dev = bcast_q || (col_dev == dev_q);
        col_hit  = 1'b0;
        if (col_vld && active) begin
            if (off_q >= GUARD_LO) col_hit = 1'b1;
            else                   col_hit = same_dev;
        end
    end

endmodule

// File: rtl/dev_power_slot.sv
// Per-device nap/powerdown tracker.
// Opens a restricted interval and a quiet interval when a nap or powerdown
// packet reaches the device while it is awake. The device counts as asleep
// when the restricted interval ends, and is awake again on a wake pulse.
// Assumes: RESTR_LEN >= 1, QUIET_LEN >= 1.
module dev_power_slot
    import slotchk_pkg::*;
#(
    parameter int RESTR_LEN = 6,
    parameter int QUIET_LEN = 4,
    parameter int DEV_W     = 2,
    parameter int IDX       = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nap_req,
    input  logic [DEV_W-1:0] nap_dev,
    input  logic             wake_vld,
    input  logic [DEV_W-1:0] wake_dev,
    output logic             restr_act,
    output logic             quiet_act,
    output logic             asleep
);
    localparam int RC_W = $clog2(RESTR_LEN + 1);
    localparam int QC_W = $clog2(QUIET_LEN + 1);
    localparam logic [DEV_W-1:0] MY_ID = DEV_W'(IDX);

    pwr_state_e      st_q;
    logic [RC_W-1:0] rcnt_q;
    logic [QC_W-1:0] qcnt_q;
    logic            arm;
    logic            wake_me;

    // Arming and wake decode for this device.
    always_comb begin
        arm     = nap_req && (nap_dev == MY_ID) && (st_q == PS_AWAKE);
        wake_me = wake_vld && (wake_dev == MY_ID) && (st_q == PS_SLEEP);
    end

    // Power state and restricted countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PS_AWAKE;
            rcnt_q <= '0;
        end else if (arm) begin
            st_q   <= PS_RESTR;
            rcnt_q <= RC_W'(RESTR_LEN);
        end else if (st_q == PS_RESTR) begin
            rcnt_q <= rcnt_q - RC_W'(1);
            if (rcnt_q == RC_W'(1)) st_q <= PS_SLEEP;
        end else if (wake_me) begin
            st_q <= PS_AWAKE;
        end
    end

    // Quiet countdown for broadcast row packets.
    always_ff @(posedge clk) begin
        if (!rst_n)              qcnt_q <= '0;
        else if (arm)            qcnt_q <= QC_W'(QUIET_LEN);
        else if (qcnt_q != '0)   qcnt_q <= qcnt_q - QC_W'(1);
    end

    assign restr_act = (st_q == PS_RESTR);
    assign quiet_act = (qcnt_q != '0);
    assign asleep    = (st_q == PS_SLEEP);

endmodule

// File: rtl/packet_slot_checker.sv
// Packet slot restriction checker (top).
// Samples one row and one column packet per cycle, and checks them against
// the relax column window and the per-device restricted and quiet
// intervals. Reports a registered violation code and a drop flag for
// packets sent to sleeping devices.
// Assumes: NDEV >= 2, FRAME >= 5; row_op is meaningful only with row_vld.
module packet_slot_checker
    import slotchk_pkg::*;
#(
    parameter int NDEV      = 4,
    parameter int FRAME     = 8,
    parameter int RESTR_LEN = 6,
    parameter int QUIET_LEN = 4,
    parameter int DEV_W     = $clog2(NDEV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_vld,
    input  logic [1:0]       row_op,
    input  logic [DEV_W-1:0] row_dev,
    input  logic             row_bcast,
    input  logic             col_vld,
    input  logic [DEV_W-1:0] col_dev,
    input  logic             wake_vld,
    input  logic [DEV_W-1:0] wake_dev,
    output logic             viol,
    output logic [2:0]       viol_code,
    output logic             drop
);
    logic [NDEV-1:0] restr_v;
    logic [NDEV-1:0] quiet_v;
    logic [NDEV-1:0] sleep_v;

    logic row_addr, nap_req, rlx_arm, col_hit;
    logic restr_hit, quiet_hit, drop_hit;
    viol_code_e code_d;

    // Qualify the row packet for arming the trackers.
    always_comb begin
        row_addr = row_vld && !row_bcast;
        nap_req  = row_addr && ((row_op == OP_NAP) || (row_op == OP_PDN));
        rlx_arm  = row_vld && (row_op == OP_RELAX) &&
                   (row_bcast || !(restr_v[row_dev] || sleep_v[row_dev]));
    end

    relax_window #(
        .FRAME (FRAME),
        .DEV_W (DEV_W)
    ) u_rlx (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (rlx_arm),
        .arm_dev   (row_dev),
        .arm_bcast (row_bcast),
        .col_vld   (col_vld),
        .col_dev   (col_dev),
        .col_hit   (col_hit)
    );

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        dev_power_slot #(
            .RESTR_LEN (RESTR_LEN),
            .QUIET_LEN (QUIET_LEN),
            .DEV_W     (DEV_W),
            .IDX       (d)
        ) u_pwr (
            .clk       (clk),
            .rst_n     (rst_n),
            .nap_req   (nap_req),
            .nap_dev   (row_dev),
            .wake_vld  (wake_vld),
            .wake_dev  (wake_dev),
            .restr_act (restr_v[d]),
            .quiet_act (quiet_v[d]),
            .asleep    (sleep_v[d])
        );
    end

    // Classify this cycle's packets and pick one code by priority.
    always_comb begin
        restr_hit = (row_addr && restr_v[row_dev]) ||
                    (col_vld  && restr_v[col_dev]);
        quiet_hit = row_vld && row_bcast && (|quiet_v);
        drop_hit  = (row_addr && sleep_v[row_dev]) ||
                    (col_vld  && sleep_v[col_dev]);
        if (restr_hit)      code_d = VC_RESTR;
        else if (quiet_hit) code_d = VC_QUIET;
        else if (col_hit)   code_d = VC_COLWIN;
        else                code_d = VC_NONE;
    end

    // Output register: one-cycle result per packet cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol      <= 1'b0;
            viol_code <= 3'd0;
            drop      <= 1'b0;
        end else begin
            viol      <= (code_d != VC_NONE);
            viol_code <= code_d;
            drop      <= drop_hit;
        end
    end

endmodule

// File: rtl/packet_slot_checker_sva.sv
// Assertion checker for packet_slot_checker, attached by bind.
// Assumes: stimulus held stable around the rising edge.
module packet_slot_checker_sva #(
    parameter int NDEV  = 4,
    parameter int DEV_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             row_vld,
    input logic [1:0]       row_op,
    input logic [DEV_W-1:0] row_dev,
    input logic             row_bcast,
    input logic             col_vld,
    input logic             viol,
    input logic [2:0]       viol_code,
    input logic             drop,
    input logic [NDEV-1:0]  quiet_v,
    input logic [NDEV-1:0]  sleep_v
);
    // R2
    flag_matches_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol == (viol_code != 3'd0));

    // R2
    code_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_code <= 3'd3);

    // R2
    idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_vld && !col_vld) |=> (!viol && !drop));

    // R5
    bcast_relax_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_vld && row_bcast && row_op == 2'd1) ##1 col_vld |=> viol);

    // R8
    quiet_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_vld && row_bcast && (|quiet_v)) |=> viol);

    // R9
    sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_vld && !row_bcast && sleep_v[row_dev]) |=> drop);

endmodule

bind packet_slot_checker packet_slot_checker_sva #(
    .NDEV  (NDEV),
    .DEV_W (DEV_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_vld   (row_vld),
    .row_op    (row_op),
    .row_dev   (row_dev),
    .row_bcast (row_bcast),
    .col_vld   (col_vld),
    .viol      (viol),
    .viol_code (viol_code),
    .drop      (drop),
    .quiet_v   (quiet_v),
    .sleep_v   (sleep_v)
);

// File: tb/packet_slot_checker_bench.sv
// Directed bench for packet_slot_checker: one task per scenario.
module packet_slot_checker_bench;
    localparam int NDEV  = 4;
    localparam int FRAME = 8;
    localparam int RL    = 6;
    localparam int QL    = 4;
    localparam int DW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          row_vld = 1'b0;
    logic [1:0]    row_op = 2'd0;
    logic [DW-1:0] row_dev = '0;
    logic          row_bcast = 1'b0;
    logic          col_vld = 1'b0;
    logic [DW-1:0] col_dev = '0;
    logic          wake_vld = 1'b0;
    logic [DW-1:0] wake_dev = '0;
    logic          viol;
    logic [2:0]    viol_code;
    logic          drop;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    packet_slot_checker #(
        .NDEV (NDEV), .FRAME (FRAME), .RESTR_LEN (RL), .QUIET_LEN (QL)
    ) u_packet_slot_checker (
        .clk (clk), .rst_n (rst_n),
        .row_vld (row_vld), .row_op (row_op), .row_dev (row_dev),
        .row_bcast (row_bcast), .col_vld (col_vld), .col_dev (col_dev),
        .wake_vld (wake_vld), .wake_dev (wake_dev),
        .viol (viol), .viol_code (viol_code), .drop (drop)
    );

    task automatic check(input string req, input logic ev, input logic [2:0] ec,
                         input logic ed);
        tests++;
        if (viol !== ev || viol_code !== ec || drop !== ed) begin
            fails++;
            $display("FAIL %s: viol=%0b code=%0d drop=%0b, expected viol=%0b code=%0d drop=%0b",
                     req, viol, viol_code, drop, ev, ec, ed);
        end
    endtask

    // One packet cycle: drive, take the edge, clear inputs, check the result.
    task automatic step(input logic rv, input logic [1:0] op, input int rd,
                        input logic rb, input logic cv, input int cd,
                        input logic wv, input int wd,
                        input string req, input logic [2:0] ec, input logic ed);
        row_vld = rv; row_op = op; row_dev = DW'(rd); row_bcast = rb;
        col_vld = cv; col_dev = DW'(cd); wake_vld = wv; wake_dev = DW'(wd);
        @(posedge clk); #1;
        row_vld = 1'b0; col_vld = 1'b0; wake_vld = 1'b0; row_bcast = 1'b0;
        check(req, ec != 3'd0, ec, ed);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R2 idle", 3'd0, 1'b0);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", 1'b0, 3'd0, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", 1'b0, 3'd0, 1'b0);
    endtask

    // R3 R4: column to same and to another device at each offset.
    task automatic t_relax_window();
        step(1, 2'd1, 0, 0, 1, 0, 0, 0, "R4 offset 0", 3'd0, 1'b0);
        for (int m = 1; m <= FRAME + 1; m++) begin
            step(1, 2'd1, 0, 0, 0, 0, 0, 0, "R4 arm", 3'd0, 1'b0);
            if (m > 1) idle(m - 1);
            step(0, 0, 0, 0, 1, 0, 0, 0, "R4 same device",
                 (m <= FRAME - 1) ? 3'd1 : 3'd0, 1'b0);
        end
        for (int m = 1; m <= FRAME + 1; m++) begin
            step(1, 2'd1, 0, 0, 0, 0, 0, 0, "R3 arm", 3'd0, 1'b0);
            if (m > 1) idle(m - 1);
            step(0, 0, 0, 0, 1, 1, 0, 0, "R3 other device",
                 (m >= FRAME - 3 && m <= FRAME - 1) ? 3'd1 : 3'd0, 1'b0);
        end
        idle(FRAME);
    endtask

    task automatic t_bcast_relax();
        step(1, 2'd1, 0, 1, 0, 0, 0, 0, "R5 arm", 3'd0, 1'b0);
        step(0, 0, 0, 0, 1, 2, 0, 0, "R5 other device offset 1", 3'd1, 1'b0);
        idle(FRAME);
    endtask

    // R6 R7 R8 R9 on device 1.
    task automatic t_nap();
        step(1, 2'd2, 1, 0, 0, 0, 0, 0, "R6 nap arm", 3'd0, 1'b0);
        step(0, 0, 0, 0, 1, 1, 0, 0, "R6 col in restricted", 3'd2, 1'b0);
        step(1, 2'd0, 2, 0, 1, 0, 0, 0, "R7 other devices", 3'd0, 1'b0);
        step(1, 2'd0, 0, 1, 0, 0, 0, 0, "R8 bcast offset 3", 3'd3, 1'b0);
        step(1, 2'd0, 0, 1, 0, 0, 0, 0, "R8 bcast offset 4", 3'd3, 1'b0);
        step(1, 2'd0, 0, 1, 0, 0, 0, 0, "R8 bcast after quiet", 3'd0, 1'b0);
        step(1, 2'd0, 1, 0, 0, 0, 0, 0, "R6 row at last offset", 3'd2, 1'b0);
        step(0, 0, 0, 0, 1, 1, 0, 0, "R9 col dropped", 3'd0, 1'b1);
        step(1, 2'd0, 1, 0, 0, 0, 1, 1, "R9 row dropped with wake", 3'd0, 1'b1);
        step(0, 0, 0, 0, 1, 1, 0, 0, "R9 awake after wake", 3'd0, 1'b0);
        idle(FRAME);
    endtask

    // R10 priority on device 2 with device 3 as bystander.
    task automatic t_priority();
        step(1, 2'd1, 2, 0, 0, 0, 0, 0, "R10 relax dev2", 3'd0, 1'b0);
        step(1, 2'd3, 2, 0, 0, 0, 0, 0, "R10 pdn dev2", 3'd0, 1'b0);
        step(1, 2'd0, 0, 1, 1, 2, 0, 0, "R10 restricted wins", 3'd2, 1'b0);
        idle(2);
        step(1, 2'd0, 0, 1, 1, 3, 0, 0, "R10 quiet over column", 3'd3, 1'b0);
        step(0, 0, 0, 0, 1, 3, 0, 0, "R3 guard slot", 3'd1, 1'b0);
        idle(RL + FRAME);
        step(0, 0, 0, 0, 0, 0, 1, 2, "R9 wake dev2", 3'd0, 1'b0);
        step(0, 0, 0, 0, 1, 2, 0, 0, "R9 dev2 awake", 3'd0, 1'b0);
        idle(FRAME);
    endtask

    // R11 relax to a sleeping device opens no window.
    task automatic t_relax_ignored();
        step(1, 2'd2, 3, 0, 0, 0, 0, 0, "R11 nap dev3", 3'd0, 1'b0);
        idle(RL);
        step(1, 2'd1, 3, 0, 0, 0, 0, 0, "R11 relax dropped", 3'd0, 1'b1);
        step(0, 0, 0, 0, 0, 0, 1, 3, "R11 wake dev3", 3'd0, 1'b0);
        step(0, 0, 0, 0, 1, 3, 0, 0, "R11 no window", 3'd0, 1'b0);
        idle(FRAME);
    endtask

    initial begin
        t_reset();
        t_relax_window();
        t_bcast_relax();
        t_nap();
        t_priority();
        t_relax_ignored();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule